// File: doc/BRIEF.md
# Processor Watchdog Supervisor with Startup Window

This block watches a single service line that a processor toggles, and drives an active-low reset line back to that processor. After any reset event it holds reset low for a fixed pulse length. It then opens a long startup window so that the system has time to boot. The first service toggle closes that window early. When the window runs out instead, the block moves on to a shorter routine window. In the routine window each toggle restarts the timeout, and a window that runs out with no toggle starts a fresh reset pulse.

Either direction of change on the service line counts as a service. The line passes through a synchronizer before its edges are detected. The manual reset request is a level and is sampled on the clock. The asynchronous power-on reset forces the pulse state at once. All periods are parameters counted in clock cycles. The startup window is the routine window multiplied by a parameter whose default is 16.

Top module: `wdog_supervisor`

## Requirements
- R1: While `por_n_i` is low, `rst_n_o` is low, and it goes low at once when `por_n_i` falls, with no clock edge needed.
- R2: Once the last reset source is removed, `rst_n_o` stays low for exactly `PULSE_CYC` cycles and then goes high as the startup window opens.
- R3: A change of `svc_i` in either direction counts as a service. The control logic acts on it at the third rising clock edge after the change (two synchronizer stages plus one edge-compare stage).
- R4: The startup window lasts `STARTUP_MULT*ROUTINE_CYC` cycles. If it runs out with no service, the routine window opens and no reset is issued.
- R5: The first service inside the startup window ends that window at once and opens a routine window of `ROUTINE_CYC` cycles.
- R6: In routine operation each service restarts the `ROUTINE_CYC` window. A service seen in the last cycle of the window restarts it and does not cause a reset.
- R7: When a routine window runs out with no service, `rst_n_o` goes low on the next cycle for `PULSE_CYC` cycles, and a full startup window follows.
- R8: Services that arrive while `rst_n_o` is low have no effect, so the pulse length is unchanged.
- R9: While `man_rst_i` is high, `rst_n_o` is low (from the cycle after it is first sampled high). The full `PULSE_CYC` pulse is timed again from the first cycle in which it is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| man_rst_i | input | 1 | Manual reset request, active high, level-sensitive, synchronous to `clk_i` |
| svc_i | input | 1 | Service line from the processor, asynchronous |
| rst_n_o | output | 1 | Reset to the processor, active low, registered |

## Verification
Each result is due a fixed number of rising edges after the event that causes it:
- **Service toggle:** it reaches the control logic at the third edge.
- **Expired window:** a reset begins on the edge right after the last counted cycle.
- **Reset pulse:** it ends `PULSE_CYC` edges after it began or after the reset source was released.
- **Startup window:** it ends `STARTUP_MULT*ROUTINE_CYC` edges after it opened.

The driver records the edge count at which it applies each stimulus. It adds these latencies to work out the exact cycle number of every expected level. It queues that level for the cycle just before the expected change and for the cycle of the change. The monitor counts edges, samples at the falling edge, and compares each queued item in exactly its cycle. An item whose cycle has passed is reported as missed.

// File: rtl/wd_pkg.sv
package wd_pkg;

  typedef enum logic [1:0] {
    ST_PULSE   = 2'd0,
    ST_STARTUP = 2'd1,
    ST_NORMAL  = 2'd2
  } wd_state_e;

  function automatic int startup_cycles(input int routine, input int mult);
    return routine * mult;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_bits(input int maxv);
    int w;
    w = $clog2(maxv + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/wd_sync_edge.sv
module wd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic d_i,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign edge_o = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/wd_window_timer.sv
module wd_window_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          por_n_i,
  input  logic          clr_i,
  input  logic [CW-1:0] last_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == last_i);
endmodule

// File: rtl/wd_ctrl_fsm.sv
module wd_ctrl_fsm
  import wd_pkg::*;
#(
  parameter int CW          = 8,
  parameter int PULSE_CYC   = 8,
  parameter int ROUTINE_CYC = 12,
  parameter int STARTUP_CYC = 48
) (
  input  logic          clk_i,
  input  logic          por_n_i,
  input  logic          man_rst_i,
  input  logic          svc_edge_i,
  input  logic          win_done_i,
  output wd_state_e     state_o,
  output logic          clr_o,
  output logic [CW-1:0] last_o,
  output logic          rst_n_o
);
  localparam logic [CW-1:0] LAST_PULSE   = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] LAST_ROUTINE = CW'(ROUTINE_CYC - 1);
  localparam logic [CW-1:0] LAST_STARTUP = CW'(STARTUP_CYC - 1);

  wd_state_e state_q, state_d;
  logic      rst_n_q;

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    if (man_rst_i) begin
      state_d = ST_PULSE;
      clr_o   = 1'b1;
    end else begin
      unique case (state_q)
        ST_PULSE: if (win_done_i) begin
          state_d = ST_STARTUP;
          clr_o   = 1'b1;
        end
        ST_STARTUP: if (svc_edge_i || win_done_i) begin
          state_d = ST_NORMAL;
          clr_o   = 1'b1;
        end
        ST_NORMAL: if (svc_edge_i) begin
          clr_o   = 1'b1;
        end else if (win_done_i) begin
          state_d = ST_PULSE;
          clr_o   = 1'b1;
        end
        default: begin
          state_d = ST_PULSE;
          clr_o   = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_STARTUP: last_o = LAST_STARTUP;
      ST_NORMAL:  last_o = LAST_ROUTINE;
      default:    last_o = LAST_PULSE;
    endcase
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      state_q <= ST_PULSE;
      rst_n_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_n_q <= (state_d != ST_PULSE);
    end
  end

  assign state_o = state_q;
  assign rst_n_o = rst_n_q;
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wd_pkg::*;
#(
  parameter int PULSE_CYC    = 1400,
  parameter int ROUTINE_CYC  = 16000,
  parameter int STARTUP_MULT = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic man_rst_i,
  input  logic svc_i,
  output logic rst_n_o
);
  localparam int STARTUP_CYC = startup_cycles(ROUTINE_CYC, STARTUP_MULT);
  localparam int LONGEST     = max2(PULSE_CYC, max2(ROUTINE_CYC, STARTUP_CYC));
  localparam int CW          = cnt_bits(LONGEST);

  // Named internal events, also observed by the bound checker.
  logic          svc_edge;
  logic          win_done;
  logic          win_clr;
  logic [CW-1:0] win_last;
  wd_state_e     state_q;

  wd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .por_n_i (por_n_i),
    .d_i     (svc_i),
    .edge_o  (svc_edge)
  );

  wd_window_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .por_n_i (por_n_i),
    .clr_i   (win_clr),
    .last_i  (win_last),
    .done_o  (win_done)
  );

  wd_ctrl_fsm #(
    .CW          (CW),
    .PULSE_CYC   (PULSE_CYC),
    .ROUTINE_CYC (ROUTINE_CYC),
    .STARTUP_CYC (STARTUP_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .por_n_i    (por_n_i),
    .man_rst_i  (man_rst_i),
    .svc_edge_i (svc_edge),
    .win_done_i (win_done),
    .state_o    (state_q),
    .clr_o      (win_clr),
    .last_o     (win_last),
    .rst_n_o    (rst_n_o)
  );
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk
  import wd_pkg::*;
(
  input logic      clk_i,
  input logic      por_n_i,
  input logic      man_rst_i,
  input logic      rst_n_o,
  input wd_state_e state_q,
  input logic      svc_edge,
  input logic      win_done
);
  AST_POR_HOLDS_LOW: assert property (@(posedge clk_i) !por_n_i |-> !rst_n_o); // R1
  AST_PULSE_EXIT: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (state_q == ST_PULSE && win_done && !man_rst_i) |=> (state_q == ST_STARTUP && rst_n_o)); // R2
  AST_STARTUP_NO_RESET: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (state_q == ST_STARTUP && !man_rst_i) |=> rst_n_o); // R4
  AST_EDGE_ENDS_STARTUP: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (state_q == ST_STARTUP && svc_edge && !man_rst_i) |=> state_q == ST_NORMAL); // R5
  AST_EDGE_KEEPS_NORMAL: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (state_q == ST_NORMAL && svc_edge && !man_rst_i) |=> (state_q == ST_NORMAL && rst_n_o)); // R6
  AST_EXPIRE_TO_PULSE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (state_q == ST_NORMAL && win_done && !svc_edge && !man_rst_i) |=> !rst_n_o); // R7
  AST_PULSE_IGNORES_EDGE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (state_q == ST_PULSE && !win_done) |=> !rst_n_o); // R8
  AST_MANUAL_HOLDS: assert property (@(posedge clk_i) disable iff (!por_n_i)
    man_rst_i |=> !rst_n_o); // R9
endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (
  .clk_i     (clk_i),
  .por_n_i   (por_n_i),
  .man_rst_i (man_rst_i),
  .rst_n_o   (rst_n_o),
  .state_q   (state_q),
  .svc_edge  (svc_edge),
  .win_done  (win_done)
);

// File: tb/wdog_supervisor_tb_top.sv
`timescale 1ns/1ps
module wdog_supervisor_tb_top;
  localparam int P = 8;
  localparam int R = 12;
  localparam int M = 4;
  localparam int S = R * M;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic man_rst = 1'b0;
  logic svc = 1'b0;
  logic rst_n;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge por_n)
    if (!por_n) cyc <= 0; else cyc <= cyc + 1;

  wdog_supervisor #(
    .PULSE_CYC(P), .ROUTINE_CYC(R), .STARTUP_MULT(M)
  ) dut_i (
    .clk_i(clk), .por_n_i(por_n), .man_rst_i(man_rst), .svc_i(svc), .rst_n_o(rst_n)
  );

  // Driver side: queue the expected level of rst_n for cycle c (in order).
  task automatic expect_at(input int c, input logic v, input string t);
    exp_t e;
    e.cyc = c; e.val = v; e.tag = t;
    q.push_back(e);
  endtask

  task automatic step_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: compares queued items in their exact cycle.
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].cyc <= cyc && por_n) begin
      e = q.pop_front();
      checks++;
      if (e.cyc != cyc) begin
        errors++;
        $display("FAIL %s missed slot: actual cycle %0d expected cycle %0d", e.tag, cyc, e.cyc);
      end else if (rst_n !== e.val) begin
        errors++;
        $display("FAIL %s cycle %0d: rst_n actual=%b expected=%b", e.tag, cyc, rst_n, e.val);
      end
    end
  end

  task automatic direct_check(input logic v, input string t);
    checks++;
    if (rst_n !== v) begin
      errors++;
      $display("FAIL %s: rst_n actual=%b expected=%b", t, rst_n, v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    direct_check(1'b0, "R1 reset state");
    por_n = 1'b1;                         // cycle 0 begins here
    // R2 pulse length, R8 edges during pulse (seen at edges 4 and 6)
    expect_at(P - 1, 1'b0, "R8");
    expect_at(P, 1'b1, "R2");
    step_to(1); svc = ~svc;
    step_to(3); svc = ~svc;
    // R4: startup opened at edge P, expires to routine at P+S, reset at P+S+R
    expect_at(P + S + R - 1, 1'b1, "R4");
    expect_at(P + S + R, 1'b0, "R7");
    expect_at(P + S + R + P - 1, 1'b0, "R7");
    expect_at(P + S + R + P, 1'b1, "R7");
    // R5/R3 rising: startup at 76, toggle at 81, seen at 84, reset at 96
    step_to(81); svc = ~svc;
    expect_at(84 + R - 1, 1'b1, "R5");
    expect_at(84 + R, 1'b0, "R5");
    expect_at(84 + R + P, 1'b1, "R5");
    // R6/R3 falling: startup at 104, toggle at 106 -> routine at 109
    step_to(106); svc = ~svc;
    step_to(118); svc = ~svc;            // seen at 121, the last window cycle
    expect_at(121, 1'b1, "R6");
    step_to(125); svc = ~svc;            // seen at 128
    expect_at(128 + R - 1, 1'b1, "R6");
    expect_at(128 + R, 1'b0, "R6");
    expect_at(128 + R + P - 1, 1'b0, "R7");
    expect_at(128 + R + P, 1'b1, "R7");
    // R7: new full startup after watchdog reset: 148 + S = 196, reset at 208
    expect_at(148 + S + R - 1, 1'b1, "R7");
    expect_at(148 + S + R, 1'b0, "R7");
    expect_at(148 + S + R + P, 1'b1, "R7");
    // R9: manual reset in startup (opened at 216)
    step_to(220); man_rst = 1'b1;
    expect_at(221, 1'b0, "R9");
    expect_at(225, 1'b0, "R9");
    step_to(226); man_rst = 1'b0;
    expect_at(226 + P - 1, 1'b0, "R9");
    expect_at(226 + P, 1'b1, "R9");
    step_to(240);
    // R1: asynchronous assertion without a clock edge
    @(posedge clk); #1 por_n = 1'b0; #0.5;
    direct_check(1'b0, "R1 async");
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 queue not drained: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: actual cycle %0d expected end before 5000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule